// File: doc/BRIEF.md
# Ultra DMA Burst Host Engine

This block is the host end of a 16-bit parallel disk link that moves data in Ultra DMA bursts, in either direction. The system side sees a plain word stream: words to send are offered on a valid/ready pair, and received words come out as single-cycle pulses. The device side sees the usual disk pins. Three legacy control pins take new roles. The write-strobe pin carries STOP in both directions. The read-strobe pin carries the host's ready-to-receive flag (active low) on reads and the host data strobe on writes. The ready input carries the device data strobe on reads and the device's ready flag (active low) on writes.

A burst starts when the device raises its request and the mode input selects Ultra DMA. The host lowers its acknowledge, asserts both chip selects and holds the address at zero. It then releases STOP and moves one word on every level change of the active strobe, in both directions. Either side may pause the burst. Either side may end it, always from a paused state, through a STOP/request handshake. After the strobe is parked high, the host places its 16-bit CRC of the burst on the data bus and releases the acknowledge, and the device captures the CRC on that rising edge. The device request and the ready pin pass through a two-flop synchroniser, so the core clock must run at least four times faster than the device strobe toggles.

Top module: `udma_burst_host`

## Requirements
- R1: After reset, dack_n, cs0_n, cs1_n, diow_n and dior_n are all 1, dd_oe is 0, and tx_ready and rx_valid are 0.
- R2: When mode_ultra is 1 and dreq is high, dack_n goes to 0 within four cycles. While dack_n is 0, cs0_n and cs1_n are 0 and da is 0.
- R3: One cycle after dack_n falls, diow_n (STOP) goes to 0. On a read (dir_write=0), dior_n goes to 0 to signal readiness. On a write (dir_write=1), dior_n stays at 1 and no word is taken from tx_data until the device holds iordy at 0.
- R4: On a write, every change of level on dior_n, in either direction, presents the next tx_data word on dd_out with dd_oe at 1. Consecutive changes are at least STB_CYCLES clock cycles apart.
- R5: On a read, every rising and every falling edge of iordy yields exactly one rx_valid pulse, with rx_data equal to dd_in as it stood at that edge.
- R6: The sender's pause stops the strobe: on a write, iordy at 1 stops all dior_n changes. The receiver's pause negates ready: on a read, sys_pause at 1 drives dior_n to 1, and no iordy edges arrive while it holds.
- R7: When host_stop_req is 1 during a burst, the host first pauses (on a read, dior_n goes to 1) and then sets diow_n to 1. It keeps dack_n at 0 until dreq falls.
- R8: When the device drops dreq during a burst, diow_n goes to 1. The strobe is parked high before dack_n rises, and a strobe edge that occurs after STOP is asserted is not treated as data.
- R9: On the cycle dack_n rises, dd_oe is 1 and dd_out holds a CRC-16 with polynomial 0x1021. The CRC is seeded with 0x4ABA when dack_n falls and is updated once per transferred word, bit 15 first (feedback = crc[15] XOR data bit; shift left; XOR 0x1021 when feedback is 1).
- R10: When mode_ultra is 0, a high dreq is ignored and dack_n stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ultra | input | 1 | 1 selects Ultra DMA; 0 leaves the block idle |
| dir_write | input | 1 | Burst direction sampled at start: 1 host to device, 0 device to host |
| sys_pause | input | 1 | Host-side pause request |
| host_stop_req | input | 1 | Host request to end the current burst |
| tx_data | input | 16 | Next word to send on a write |
| tx_valid | input | 1 | tx_data holds a word |
| tx_ready | output | 1 | Word on tx_data is taken this cycle |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | One-cycle pulse per received word |
| burst_done | output | 1 | One-cycle pulse after the CRC has been handed over |
| dreq | input | 1 | Device DMA request (asynchronous) |
| iordy | input | 1 | Device strobe on reads, device ready (low) on writes |
| dd_in | input | 16 | Data bus as driven by the device |
| dack_n | output | 1 | DMA acknowledge, active low |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| da | output | 3 | Device address, held low |
| diow_n | output | 1 | STOP (1 = asserted) |
| dior_n | output | 1 | Host ready (low) on reads, host strobe on writes |
| dd_out | output | 16 | Data bus value driven by the host |
| dd_oe | output | 1 | Host drives dd_out onto the bus |

## Verification
Nearly any corrupted sequencer or CRC state shows up at the ports. A stuck or skipped state appears as an acknowledge that never falls or never rises, or as STOP changing out of turn. A wrong strobe count or a lost edge makes the word sequence on dd_out or rx_data diverge at the very next edge. A wrong CRC register stays hidden until the one cycle in which dack_n rises, when the word on dd_out differs from the running CRC of the words seen. A park edge wrongly counted as data gives both an extra rx_valid pulse and a wrong CRC at that same release.

// File: rtl/udma_pkg.sv
package udma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // no burst, acknowledge released
        ST_ARM,     // acknowledge given, STOP about to be released
        ST_XFER,    // words moving
        ST_HPAUSE,  // host ending: paused, STOP next
        ST_STOPW,   // STOP asserted, waiting for request to drop
        ST_PARK,    // strobe being parked high
        ST_CRCD,    // CRC on bus, acknowledge released next
        ST_CRCR     // acknowledge released, tidy up
    } udma_state_e;

    localparam logic [15:0] UDMA_CRC_POLY = 16'h1021;
    localparam logic [15:0] UDMA_CRC_SEED = 16'h4ABA;
endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int            W       = 2,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] edge_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign sync_o = stg_q[STAGES-1];
    assign edge_o = stg_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16 #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = udma_pkg::UDMA_CRC_POLY,
    parameter logic [W-1:0] SEED = udma_pkg::UDMA_CRC_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_i,
    input  logic         upd_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_d, crc_q;

    always_comb begin
        logic [W-1:0] c;
        logic         fb;
        c  = crc_q;
        fb = 1'b0;
        if (seed_i) begin
            c = SEED;
        end else if (upd_i) begin
            for (int i = W - 1; i >= 0; i--) begin
                fb = c[W-1] ^ word_i[i];
                c  = {c[W-2:0], 1'b0};
                if (fb) c = c ^ POLY;
            end
        end
        crc_d = c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/udma_burst_host.sv
module udma_burst_host
    import udma_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 3,
    parameter int STB_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ultra,
    input  logic          dir_write,
    input  logic          sys_pause,
    input  logic          host_stop_req,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          burst_done,
    input  logic          dreq,
    input  logic          iordy,
    input  logic [DW-1:0] dd_in,
    output logic          dack_n,
    output logic          cs0_n,
    output logic          cs1_n,
    output logic [AW-1:0] da,
    output logic          diow_n,
    output logic          dior_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe
);
    localparam int CW = $clog2(STB_CYCLES + 1);
    localparam logic [CW-1:0] HOLD = CW'(STB_CYCLES - 1);

    typedef struct packed {
        udma_state_e   st;
        logic          wr;
        logic          dack_n;
        logic          cs_n;
        logic          stop;
        logic          dior_n;
        logic [DW-1:0] dout;
        logic          oe;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rx;
        logic          rxv;
        logic          done;
    } regs_t;

    localparam regs_t RST_REGS = '{
        st: ST_IDLE, wr: 1'b0, dack_n: 1'b1, cs_n: 1'b1, stop: 1'b1,
        dior_n: 1'b1, dout: '0, oe: 1'b0, cnt: '0, rx: '0, rxv: 1'b0,
        done: 1'b0
    };

    regs_t r_d, r_q;

    // bit 0: device request, bit 1: ready pin (idles high)
    logic [1:0] pin_s, pin_e;
    logic       dreq_s, rdy_s, rdy_edge;

    udma_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({iordy, dreq}),
        .sync_o (pin_s),
        .edge_o (pin_e)
    );
    assign dreq_s   = pin_s[0];
    assign rdy_s    = pin_s[1];
    assign rdy_edge = pin_e[1];

    logic          crc_seed, crc_upd;
    logic [DW-1:0] crc_word, crc_val;

    udma_crc16 #(.W(DW)) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .seed_i(crc_seed),
        .upd_i (crc_upd),
        .word_i(crc_word),
        .crc_o (crc_val)
    );

    always_comb begin
        logic take_rx;
        r_d      = r_q;
        r_d.rxv  = 1'b0;
        r_d.done = 1'b0;
        crc_seed = 1'b0;
        crc_upd  = 1'b0;
        crc_word = tx_data;
        tx_ready = 1'b0;
        take_rx  = 1'b0;
        if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (mode_ultra && dreq_s) begin
                    r_d.st     = ST_ARM;
                    r_d.wr     = dir_write;
                    r_d.dack_n = 1'b0;
                    r_d.cs_n   = 1'b0;
                    r_d.cnt    = '0;
                    crc_seed   = 1'b1;
                end
            end
            ST_ARM: begin
                r_d.stop = 1'b0;
                if (r_q.wr) r_d.oe     = 1'b1;
                else        r_d.dior_n = sys_pause;
                r_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (!dreq_s) begin
                    // device ends the burst: acknowledge with STOP
                    r_d.st   = ST_PARK;
                    r_d.stop = 1'b1;
                    if (!r_q.wr) r_d.dior_n = 1'b1;
                end else if (host_stop_req) begin
                    r_d.st = ST_HPAUSE;
                    if (!r_q.wr) r_d.dior_n = 1'b1;
                    take_rx = !r_q.wr;
                end else if (r_q.wr) begin
                    if (!rdy_s && tx_valid && !sys_pause && r_q.cnt == '0) begin
                        tx_ready   = 1'b1;
                        r_d.dout   = tx_data;
                        r_d.dior_n = ~r_q.dior_n;
                        r_d.cnt    = HOLD;
                        crc_upd    = 1'b1;
                    end
                end else begin
                    r_d.dior_n = sys_pause;
                    take_rx    = 1'b1;
                end
            end
            ST_HPAUSE: begin
                r_d.stop = 1'b1;
                r_d.st   = ST_STOPW;
                take_rx  = !r_q.wr;
            end
            ST_STOPW: begin
                if (!dreq_s) r_d.st = ST_PARK;
            end
            ST_PARK: begin
                if (r_q.wr ? r_q.dior_n : rdy_s) begin
                    r_d.dout = crc_val;
                    r_d.oe   = 1'b1;
                    r_d.st   = ST_CRCD;
                end else if (r_q.wr) begin
                    r_d.dior_n = 1'b1;
                end
            end
            ST_CRCD: begin
                r_d.dack_n = 1'b1;
                r_d.st     = ST_CRCR;
            end
            ST_CRCR: begin
                r_d.oe     = 1'b0;
                r_d.cs_n   = 1'b1;
                r_d.dior_n = 1'b1;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d = RST_REGS;
        endcase

        if (take_rx && rdy_edge) begin
            r_d.rx   = dd_in;
            r_d.rxv  = 1'b1;
            crc_upd  = 1'b1;
            crc_word = dd_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_REGS;
        else        r_q <= r_d;
    end

    assign dack_n     = r_q.dack_n;
    assign cs0_n      = r_q.cs_n;
    assign cs1_n      = r_q.cs_n;
    assign da         = '0;
    assign diow_n     = r_q.stop;
    assign dior_n     = r_q.dior_n;
    assign dd_out     = r_q.dout;
    assign dd_oe      = r_q.oe;
    assign rx_data    = r_q.rx;
    assign rx_valid   = r_q.rxv;
    assign burst_done = r_q.done;

    AST_SELECT_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !dack_n |-> (!cs0_n && !cs1_n && da == '0)); // R2
    AST_WR_STROBE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack_n && r_q.wr && !diow_n && !$stable(dior_n)) |-> !$past(rdy_s)); // R3
    AST_RX_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!dack_n && !r_q.wr)); // R5
    AST_READ_PAUSED_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(diow_n) && !dack_n && !r_q.wr) |-> dior_n); // R7
    AST_CRC_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack_n) |-> (dd_oe && dd_out == crc_val && diow_n)); // R9
    AST_ACK_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dack_n) |-> $past(mode_ultra)); // R10
endmodule

// File: tb/udma_burst_host_tb_top.sv
module udma_burst_host_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STB        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ultra = 1'b0, dir_write = 1'b0, sys_pause = 1'b0, host_stop_req = 1'b0;
    logic [15:0] tx_data;
    logic        tx_valid = 1'b0, tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid, burst_done;
    logic        dreq = 1'b0, iordy = 1'b1;
    logic [15:0] dd_in = '0;
    logic        dack_n, cs0_n, cs1_n, diow_n, dior_n, dd_oe;
    logic [2:0]  da;
    logic [15:0] dd_out;

    udma_burst_host #(.STB_CYCLES(STB)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_ultra(mode_ultra), .dir_write(dir_write),
        .sys_pause(sys_pause), .host_stop_req(host_stop_req),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .burst_done(burst_done),
        .dreq(dreq), .iordy(iordy), .dd_in(dd_in),
        .dack_n(dack_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da),
        .diow_n(diow_n), .dior_n(dior_n), .dd_out(dd_out), .dd_oe(dd_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int i = 15; i >= 0; i--) begin
            logic fb = r[15] ^ w[i];
            r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

    function automatic logic [15:0] wr_word(input int k);
        return 16'hA500 ^ 16'(k * 16'h0137);
    endfunction
    function automatic logic [15:0] rd_word(input int k);
        return 16'h3C0F + 16'(k * 16'h1111);
    endfunction

    int tx_idx = 0;
    assign tx_data = wr_word(tx_idx);
    always @(posedge clk) if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;

    // port monitor
    int          wr_cnt = 0, rx_cnt = 0, last_edge = 0, releases = 0;
    logic        prev_dior = 1'b1, prev_dack = 1'b1;
    logic [15:0] exp_crc = 16'h4ABA;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_dack && !dack_n) exp_crc = 16'h4ABA;
            if (!dack_n && dir_write && !diow_n && dior_n != prev_dior) begin
                chk(dd_oe && dd_out == wr_word(wr_cnt), "R4 word on strobe edge", dd_out, wr_word(wr_cnt));
                if (wr_cnt > 0)
                    chk(cyc - last_edge >= STB, "R4 strobe spacing", cyc - last_edge, STB);
                exp_crc   = crc_step(exp_crc, wr_word(wr_cnt));
                wr_cnt++;
                last_edge = cyc;
            end
            if (rx_valid) begin
                chk(rx_data == rd_word(rx_cnt), "R5 received word", rx_data, rd_word(rx_cnt));
                exp_crc = crc_step(exp_crc, rd_word(rx_cnt));
                rx_cnt++;
            end
            if (!prev_dack && dack_n) begin
                chk(dd_oe && dd_out == exp_crc, "R9 CRC at acknowledge release", dd_out, exp_crc);
                chk(dior_n == 1'b1, "R8 strobe parked high", dior_n, 1);
                chk(diow_n == 1'b1, "R7 STOP asserted at release", diow_n, 1);
                releases++;
            end
        end
        prev_dior = dior_n;
        prev_dack = dack_n;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        chk(dack_n && cs0_n && cs1_n, "R1 ack and selects idle", {dack_n, cs0_n, cs1_n}, 3'b111);
        chk(diow_n && dior_n, "R1 control strobes idle", {diow_n, dior_n}, 2'b11);
        chk(!dd_oe && !tx_ready && !rx_valid, "R1 bus and stream idle", {dd_oe, tx_ready, rx_valid}, 0);
    endtask

    task automatic test_mode_off();
        mode_ultra = 1'b0;
        dreq = 1'b1;
        cycles(20);
        chk(dack_n == 1'b1, "R10 request ignored in multiword mode", dack_n, 1);
        dreq = 1'b0;
        cycles(5);
        mode_ultra = 1'b1;
    endtask

    task automatic test_write();
        int n;
        dir_write = 1'b1;
        tx_valid  = 1'b1;
        iordy     = 1'b1;
        dreq      = 1'b1;
        cycles(4);
        chk(dack_n == 1'b0, "R2 acknowledge given", dack_n, 0);
        chk(!cs0_n && !cs1_n && da == 3'd0, "R2 selects and address", {cs0_n, cs1_n, da}, 0);
        cycles(2);
        chk(diow_n == 1'b0, "R3 STOP released", diow_n, 1'b0);
        cycles(15);
        chk(dior_n == 1'b1 && wr_cnt == 0, "R3 no strobe before device ready", wr_cnt, 0);
        iordy = 1'b0;
        while (wr_cnt < 5) @(negedge clk);
        iordy = 1'b1;
        cycles(6);
        n = wr_cnt;
        cycles(30);
        chk(wr_cnt == n, "R6 device pause halts strobe", wr_cnt, n);
        iordy = 1'b0;
        while (wr_cnt < 9) @(negedge clk);
        iordy = 1'b1;
        cycles(10);
        dreq = 1'b0;
        cycles(4);
        chk(diow_n == 1'b1, "R8 STOP answers dropped request", diow_n, 1);
        while (dack_n == 1'b0) @(negedge clk);
        chk(wr_cnt == tx_idx, "R4 words taken equal strobe edges", wr_cnt, tx_idx);
        cycles(5);
        chk(!dd_oe && cs0_n, "R1 bus released after burst", {dd_oe, cs0_n}, 1);
        tx_valid = 1'b0;
    endtask

    task automatic send_rd(input int k);
        while (dior_n != 1'b0) @(negedge clk);
        dd_in = rd_word(k);
        cycles(3);
        iordy = ~iordy;
        cycles(3);
    endtask

    task automatic test_read();
        int n;
        dir_write = 1'b0;
        rx_cnt    = 0;
        iordy     = 1'b1;
        dreq      = 1'b1;
        cycles(6);
        chk(dack_n == 1'b0 && diow_n == 1'b0, "R3 read start STOP released", {dack_n, diow_n}, 0);
        chk(dior_n == 1'b0, "R3 host ready on read", dior_n, 0);
        for (int k = 0; k < 4; k++) send_rd(k);
        cycles(4);
        chk(rx_cnt == 4, "R5 one word per strobe edge", rx_cnt, 4);
        sys_pause = 1'b1;
        cycles(2);
        chk(dior_n == 1'b1, "R6 host pause negates ready", dior_n, 1);
        n = rx_cnt;
        cycles(20);
        chk(rx_cnt == n, "R6 nothing received while paused", rx_cnt, n);
        sys_pause = 1'b0;
        for (int k = 4; k < 7; k++) send_rd(k);
        cycles(4);
        chk(rx_cnt == 7, "R5 words after resume", rx_cnt, 7);
        host_stop_req = 1'b1;
        cycles(3);
        host_stop_req = 1'b0;
        chk(diow_n && dior_n, "R7 host pauses then asserts STOP", {diow_n, dior_n}, 2'b11);
        cycles(10);
        chk(dack_n == 1'b0, "R7 waits for request to drop", dack_n, 0);
        dreq = 1'b0;
        cycles(2);
        iordy = 1'b1;
        while (dack_n == 1'b0) @(negedge clk);
        cycles(4);
        chk(rx_cnt == 7, "R8 park edge not taken as data", rx_cnt, 7);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        test_reset();
        test_mode_off();
        test_write();
        test_read();
        chk(releases == 2, "R9 two CRC hand-overs", releases, 2);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule